// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block pairs an 8-bit real-time counter with an 8-bit watchdog counter. A single 8-bit prescaler serves one of them at a time. One option bit picks the owner. When the timer owns the prescaler, it divides the timer's count source before the counter. When the watchdog owns it, the prescaler counts watchdog counter overflows, so it lengthens the timeout as a postscaler. The counter without the prescaler always runs undivided. Three select bits pick the tap of the prescaler that sets the divide ratio. Software cannot read or write the prescaler.

The timer counts either pulses of the system clock enable or edges of an external pin. The pin is synchronized first, and an option bit selects the rising or the falling edge. Software can read and load the timer through a data port. A wrap from all ones to zero gives a one-cycle rollover pulse, which reaches the interrupt output only when the interrupt-enable bit is set.

The watchdog counts a slow tick enable that comes from an oscillator outside the block. Software clears it with a strobe. On timeout it gives a one-cycle reset pulse, but only while the fuse enable input is high.

Top module: `tmr_wdt_top`

## Requirements
- R1: After reset the timer reads 0, no pulse is output, and the option word is 0x0F. With the fuse enabled, the first watchdog reset therefore comes on tick 32768 (256 x 128) and not on tick 32767.
- R2: Option word layout: bits [2:0] are the rate select S, bit 3 is the owner (1 = watchdog, 0 = timer), bit 4 is the pin edge (1 = falling), bit 5 is the source (1 = external pin, 0 = system enable), and bit 6 is the interrupt enable. When the timer owns the prescaler, the timer advances once per 2^(S+1) source events, and the watchdog times out every 256 ticks.
- R3: When the watchdog owns the prescaler, the timer advances on every source event.
- R4: When the watchdog owns the prescaler, a timeout occurs after 256 x 2^S ticks. It gives exactly one cycle of wdt_rst_o and clears the watchdog counter and the prescaler, so the next timeout takes the full period again.
- R5: With the fuse enable at 0, wdt_rst_o never asserts, however many ticks arrive.
- R6: The clear strobe zeroes the watchdog counter, and also zeroes the prescaler when the watchdog owns it.
- R7: A timer write loads the written value. When the timer owns the prescaler, the write also zeroes the prescaler.
- R8: With the external source selected, the timer counts synchronized pin edges of the selected polarity and ignores the system enable.
- R9: A timer wrap from 0xFF to 0x00 gives a one-cycle roll_o pulse. irq_o repeats that pulse only when the interrupt-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_we_i | input | 1 | Option word write strobe |
| opt_wdata_i | input | 7 | Option word value |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| sys_en_i | input | 1 | Internal count enable |
| wdt_tick_i | input | 1 | Slow watchdog tick enable |
| wdt_clr_i | input | 1 | Clear-watchdog strobe |
| fuse_wdt_en_i | input | 1 | Watchdog reset enable |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | 8 | Timer write data |
| tmr_rdata_o | output | 8 | Timer value |
| roll_o | output | 1 | Timer rollover pulse |
| irq_o | output | 1 | Rollover interrupt pulse |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench uses the default widths: 8-bit counters, an 8-bit prescaler and a 3-bit rate select. At these sizes the longest default timeout of 32768 ticks fits in a short run. This makes the exact reset-value timeout reachable, together with the short 256- and 512-tick periods on either side of a clear. Rollover is driven both with and without the interrupt enable. Pin counting is driven with both edge polarities, using a stimulus in which the rising and falling edge counts differ.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  parameter int unsigned SEL_W = 3;

  typedef struct packed {
    logic             ien;
    logic             src_ext;
    logic             edge_fall;
    logic             wdt_own;
    logic [SEL_W-1:0] sel;
  } opt_t;

  localparam int unsigned OPT_W = $bits(opt_t);
  localparam opt_t OPT_RST = '{ien: 1'b0, src_ext: 1'b0, edge_fall: 1'b0,
                               wdt_own: 1'b1, sel: '1};
endpackage

// File: rtl/tmr_wdt_edge_sync.sv
module tmr_wdt_edge_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  // sh_q[SYNC_N-1] is the synchronized level, sh_q[SYNC_N] its previous value
  assign evt_o = fall_i ? (~sh_q[SYNC_N-1] &  sh_q[SYNC_N])
                        : ( sh_q[SYNC_N-1] & ~sh_q[SYNC_N]);
endmodule

// File: rtl/tmr_wdt_prescaler.sv
module tmr_wdt_prescaler #(
  parameter int unsigned PS_W  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pre_i,   // 1: one extra stage (timer role)
  output logic             tap_o
);
  localparam int unsigned SPAN_W = SEL_W + 1;

  logic [PS_W-1:0]   cnt_q;
  logic [PS_W-1:0]   mask;
  logic [SPAN_W-1:0] span;

  assign span = {1'b0, sel_i} + SPAN_W'(pre_i);

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign mask[i] = (32'(span) > 32'(i));
  end

  assign tap_o = inc_i & (&(cnt_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  a_r6_ps_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tmr_wdt_wdog.sv
module tmr_wdt_wdog #(
  parameter int unsigned WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic [WDT_W-1:0] cnt_q;

  assign ovf_o = tick_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  a_r6_wdt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  a_r4_wdt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !ovf_o) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tmr_wdt_rtc.sv
module tmr_wdt_rtc #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             roll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      roll_q <= inc_i & ~we_i & (&cnt_q);
      if (we_i)       cnt_q <= wdata_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign roll_o = roll_q;

  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cnt_o == $past(wdata_i));
  a_r9_roll_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_o |-> cnt_o == '0);
endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned WDT_W  = 8,
  parameter int unsigned PS_W   = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          opt_we_i,
  input  logic [tmr_wdt_pkg::OPT_W-1:0] opt_wdata_i,
  input  logic                          ext_pin_i,
  input  logic                          sys_en_i,
  input  logic                          wdt_tick_i,
  input  logic                          wdt_clr_i,
  input  logic                          fuse_wdt_en_i,
  input  logic                          tmr_we_i,
  input  logic [CNT_W-1:0]              tmr_wdata_i,
  output logic [CNT_W-1:0]              tmr_rdata_o,
  output logic                          roll_o,
  output logic                          irq_o,
  output logic                          wdt_rst_o
);
  import tmr_wdt_pkg::*;

  opt_t opt_q;
  logic pin_evt, tmr_src, wdt_ovf, ps_inc, ps_clr, ps_tap;
  logic tmr_inc, wdt_timeout, wdt_fire, wdt_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       opt_q <= OPT_RST;
    else if (opt_we_i) opt_q <= opt_t'(opt_wdata_i);
  end

  tmr_wdt_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .fall_i(opt_q.edge_fall), .evt_o(pin_evt)
  );

  assign tmr_src = opt_q.src_ext ? pin_evt : sys_en_i;

  // Prescaler routing: watchdog owner -> postscaler on overflows; else timer prescaler
  assign ps_inc      = opt_q.wdt_own ? wdt_ovf : tmr_src;
  assign ps_clr      = opt_q.wdt_own ? (wdt_clr_i | wdt_fire) : tmr_we_i;
  assign tmr_inc     = opt_q.wdt_own ? tmr_src : ps_tap;
  assign wdt_timeout = opt_q.wdt_own ? ps_tap  : wdt_ovf;
  assign wdt_fire    = wdt_timeout & fuse_wdt_en_i;

  tmr_wdt_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
    .clk_i, .rst_ni, .inc_i(ps_inc), .clr_i(ps_clr),
    .sel_i(opt_q.sel), .pre_i(~opt_q.wdt_own), .tap_o(ps_tap)
  );

  tmr_wdt_wdog #(.WDT_W(WDT_W)) u_wdog (
    .clk_i, .rst_ni, .tick_i(wdt_tick_i), .clr_i(wdt_clr_i | wdt_fire), .ovf_o(wdt_ovf)
  );

  tmr_wdt_rtc #(.CNT_W(CNT_W)) u_rtc (
    .clk_i, .rst_ni, .inc_i(tmr_inc), .we_i(tmr_we_i), .wdata_i(tmr_wdata_i),
    .cnt_o(tmr_rdata_o), .roll_o(roll_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdt_rst_q <= 1'b0;
    else         wdt_rst_q <= wdt_fire;
  end

  assign wdt_rst_o = wdt_rst_q;
  assign irq_o     = roll_o & opt_q.ien;

  a_r5_fuse_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(fuse_wdt_en_i));
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  a_r9_irq_needs_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> roll_o);
endmodule

// File: tb/tb_tmr_wdt_top.sv
module tb_tmr_wdt_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       opt_we = 0, ext_pin = 0, sys_en = 0, wdt_tick = 0, wdt_clr = 0;
  logic       fuse = 0, tmr_we = 0;
  logic [6:0] opt_wdata = '0;
  logic [7:0] tmr_wdata = '0, tmr_rdata;
  logic       roll, irq, wdt_rst;

  tmr_wdt_top dut (
    .clk_i(clk), .rst_ni(rst_n), .opt_we_i(opt_we), .opt_wdata_i(opt_wdata),
    .ext_pin_i(ext_pin), .sys_en_i(sys_en), .wdt_tick_i(wdt_tick), .wdt_clr_i(wdt_clr),
    .fuse_wdt_en_i(fuse), .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_wdata),
    .tmr_rdata_o(tmr_rdata), .roll_o(roll), .irq_o(irq), .wdt_rst_o(wdt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kinds: 0 timer value, 1 reset pulses, 2 roll pulses, 3 irq pulses, 4 longest reset pulse
  typedef struct { string tag; int kind; int exp; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0, rst_cnt = 0, roll_cnt = 0, irq_cnt = 0, rst_run = 0, rst_max = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst) begin rst_cnt++; rst_run++; if (rst_run > rst_max) rst_max = rst_run; end
      else rst_run = 0;
      if (roll) roll_cnt++;
      if (irq)  irq_cnt++;
    end
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = int'(tmr_rdata);
        1: act = rst_cnt;
        2: act = roll_cnt;
        3: act = irq_cnt;
        default: act = rst_max;
      endcase
      n_cmp++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s kind %0d: actual %0d expected %0d", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(string tag, int kind, int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
    @(negedge clk);
    idle(1);
  endtask

  task automatic set_opt(bit ien, bit src, bit edg, bit own, int sel);
    opt_wdata = {ien, src, edg, own, 3'(sel)};
    opt_we = 1; idle(1); opt_we = 0;
  endtask

  task automatic tmr_write(int v);
    tmr_wdata = 8'(v); tmr_we = 1; idle(1); tmr_we = 0;
  endtask

  task automatic sys_pulses(int n);
    sys_en = 1; idle(n); sys_en = 0; idle(3);
  endtask

  task automatic ticks(int n);
    wdt_tick = 1; idle(n); wdt_tick = 0; idle(3);
  endtask

  task automatic clr_strobe();
    wdt_clr = 1; idle(1); wdt_clr = 0;
  endtask

  task automatic pin_pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1; idle(4); ext_pin = 0; idle(4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    expect_item("R1", 0, 0);
    expect_item("R1", 1, 0);
    expect_item("R1", 2, 0);
    // R1 default 1:128 postscaled timeout
    fuse = 1;
    ticks(32767);
    expect_item("R1", 1, 0);
    ticks(1);
    expect_item("R1", 1, 1);

    // R2 timer owns prescaler, S=2 -> /8
    set_opt(1, 0, 0, 0, 2);
    tmr_write(0);
    sys_pulses(16);
    expect_item("R2", 0, 2);
    ticks(255);
    expect_item("R2", 1, 1);
    ticks(1);
    expect_item("R2", 1, 2);
    expect_item("R2", 0, 2);

    // R7 write zeroes prescaler when timer owns it
    sys_pulses(5);
    tmr_write(8'hFE);
    expect_item("R7", 0, 8'hFE);
    sys_pulses(7);
    expect_item("R7", 0, 8'hFE);
    sys_pulses(1);
    expect_item("R7", 0, 8'hFF);
    // R9 rollover with interrupt enabled
    sys_pulses(8);
    expect_item("R9", 0, 0);
    expect_item("R9", 2, 1);
    expect_item("R9", 3, 1);
    set_opt(0, 0, 0, 0, 2);
    sys_pulses(2048);
    expect_item("R9", 2, 2);
    expect_item("R9", 3, 1);

    // R3 watchdog owns prescaler: timer undivided
    set_opt(0, 0, 0, 1, 0);
    tmr_write(8'h10);
    sys_pulses(5);
    expect_item("R3", 0, 8'h15);

    // R4 S=1 -> 512 ticks, then full period again
    set_opt(0, 0, 0, 1, 1);
    clr_strobe();
    ticks(511);
    expect_item("R4", 1, 2);
    ticks(1);
    expect_item("R4", 1, 3);
    ticks(511);
    expect_item("R4", 1, 3);
    ticks(1);
    expect_item("R4", 1, 4);

    // R6 clear zeroes counter and owned prescaler
    ticks(300);
    clr_strobe();
    ticks(511);
    expect_item("R6", 1, 4);
    ticks(1);
    expect_item("R6", 1, 5);

    // R5 fuse off
    fuse = 0;
    ticks(1200);
    expect_item("R5", 1, 5);
    expect_item("R4", 4, 1);

    // R8 external pin, rising edges, system enable ignored
    set_opt(0, 1, 0, 1, 1);
    tmr_write(0);
    sys_en = 1;
    pin_pulses(3);
    ext_pin = 1; idle(8);
    expect_item("R8", 0, 4);
    ext_pin = 0; idle(8);
    set_opt(0, 1, 1, 1, 1);
    tmr_write(0);
    pin_pulses(3);
    ext_pin = 1; idle(8);
    expect_item("R8", 0, 3);
    sys_en = 0;
    ext_pin = 0; idle(8);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule